// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block connects a single-request host port to an external asynchronous static RAM of 32K bytes. The host presents one request at a time: a valid flag, a read/write select, an address and write data. The sequencer drives the RAM's active-low chip-select, output-gate and write-strobe pins, the address, and the data bus. It then signals completion with a one-cycle done pulse. For reads, the captured byte appears on the read-data output on that same pulse.

The external RAM sets minimum times in nanoseconds. The sequencer converts each one into a whole number of clock cycles from a clock-period parameter. Each count is rounded up and is never less than one. A speed-grade parameter selects the faster or the slower set of limits.

The data bus is split into an output value, an output-enable and an input value, so that a pad-level tri-state buffer can be placed at the chip edge. Requests that arrive while an access is in progress are dropped. The host should raise a request only while the sequencer is idle and wait for done before raising the next.

Top module: `asram_sequencer`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, the outputs are at rest: chip-select, output-gate and write-strobe are all high (inactive), the data bus is not driven, done is low, and read data is zero.
- R2: A write accepted in idle produces the following sequence, with chip-select low from the first cycle to the last active cycle. First, one setup cycle with write-strobe high and the bus undriven. Then the write-strobe pulse with the bus driven with the write byte. Then hold cycles with write-strobe high and the bus still driven. Finally, one done cycle with all strobes high and the bus released.
- R3: The write-strobe pulse lasts exactly ceil(max(pulse, data-setup) / period) cycles. The chip-select-low span of any access is at least the cycle-time minimum, with at least one cycle per phase.
- R4: A read accepted in idle holds chip-select and output-gate low for ceil(max(address-access, output-access, cycle) / period) cycles. The byte on the input bus is registered at the end of the last of these cycles. Done pulses in the next cycle with that byte on read data, and read data changes at no other time.
- R5: Output-gate stays high for the whole of a write and never changes while chip-select is low.
- R6: Write-strobe stays high for the whole of a read; it is never low while output-gate is low.
- R7: The data bus is driven only while chip-select is low and output-gate is high.
- R8: The address does not change while chip-select stays low.
- R9: A request is taken only in idle. A request raised during any busy cycle, including the done cycle, leaves the sequence and the following idle cycle unchanged.
- R10: With the slow speed grade at the default 10 ns clock, a write holds write-strobe low for 5 cycles and chip-select low for 7 cycles, and a read holds chip-select low for 7 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present (taken only in idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Request byte address |
| req_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Last byte read |
| done | output | 1 | One-cycle completion strobe |
| ram_cs_n | output | 1 | RAM chip-select, active low |
| ram_og_n | output | 1 | RAM output-gate, active low |
| ram_ws_n | output | 1 | RAM write-strobe, active low |
| ram_addr | output | 15 | RAM address |
| ram_dq_out | output | 8 | Value for the RAM data bus |
| ram_dq_oe | output | 1 | Data bus drive enable for the pad buffer |
| ram_dq_in | input | 8 | Value sampled from the RAM data bus |

## Verification
The bench targets requests held high through an entire access, including the done cycle. A design that accepts in the done cycle would start a second access with no idle cycle in between. It also issues a write immediately followed by a read of the same address, and reads of unwritten locations. A wrong hold or capture timing would return stale or undriven data there. A behavioural RAM flags several faults: bus drive while the output gate is low, the output gate moving during an access, an address change under a low chip-select, and a write pulse shorter than its computed length. A design that releases the bus one cycle early, or counts the pulse from the wrong edge, shows up as a pulse or cycle count that does not match.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_RACCESS,
    ST_DONE
  } asram_state_e;

  function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                               input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int unsigned SU_CYC   = 1,
  parameter int unsigned WP_CYC   = 4,
  parameter int unsigned HOLD_CYC = 1,
  parameter int unsigned RD_CYC   = 6,
  parameter int          CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             expired,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept,
  output logic             capture,
  output logic             cs_n,
  output logic             og_n,
  output logic             ws_n,
  output logic             dq_oe,
  output logic             done
);

  asram_state_e state_q, nxt;

  always_comb begin
    nxt      = state_q;
    load     = 1'b0;
    load_val = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          load   = 1'b1;
          if (req_write) begin
            nxt      = ST_WSETUP;
            load_val = CNT_W'(SU_CYC - 1);
          end else begin
            nxt      = ST_RACCESS;
            load_val = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_WSETUP: begin
        if (expired) begin
          nxt      = ST_WPULSE;
          load     = 1'b1;
          load_val = CNT_W'(WP_CYC - 1);
        end
      end
      ST_WPULSE: begin
        if (expired) begin
          nxt      = ST_WHOLD;
          load     = 1'b1;
          load_val = CNT_W'(HOLD_CYC - 1);
        end
      end
      ST_WHOLD: begin
        if (expired) nxt = ST_DONE;
      end
      ST_RACCESS: begin
        if (expired) begin
          nxt     = ST_DONE;
          capture = 1'b1;
        end
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cs_n    <= 1'b1;
      og_n    <= 1'b1;
      ws_n    <= 1'b1;
      dq_oe   <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= nxt;
      cs_n    <= (nxt == ST_IDLE) || (nxt == ST_DONE);
      og_n    <= (nxt != ST_RACCESS);
      ws_n    <= (nxt != ST_WPULSE);
      dq_oe   <= (nxt == ST_WPULSE) || (nxt == ST_WHOLD);
      done    <= (nxt == ST_DONE);
    end
  end

  assert_oe_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(!cs_n)) |-> $stable(og_n));

  assert_we_high_read_R6: assert property (@(posedge clk) disable iff (rst)
    (!og_n) |-> ws_n);

  assert_bus_safe_R7: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (og_n && !cs_n));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE) |=> (state_q == ST_IDLE));

  assert_reset_rest_R1: assert property (@(posedge clk)
    rst |=> (cs_n && og_n && ws_n && !dq_oe && !done));

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  input  logic              cs_n,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr    <= '0;
      dq_out  <= '0;
      rd_data <= '0;
    end else begin
      if (accept) begin
        addr   <= req_addr;
        dq_out <= req_wdata;
      end
      if (capture) rd_data <= dq_in;
    end
  end

  assert_addr_steady_R8: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(!cs_n)) |-> $stable(addr));

endmodule

// File: rtl/asram_sequencer.sv
module asram_sequencer
  import asram_pkg::*;
#(
  parameter int          ADDR_W        = 15,
  parameter int          DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter bit          SLOW_GRADE    = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              ram_cs_n,
  output logic              ram_og_n,
  output logic              ram_ws_n,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);

  localparam int unsigned T_CYCLE = SLOW_GRADE ? 70 : 55;
  localparam int unsigned T_PULSE = SLOW_GRADE ? 50 : 40;
  localparam int unsigned T_DSU   = SLOW_GRADE ? 30 : 25;
  localparam int unsigned T_ACC   = SLOW_GRADE ? 70 : 55;
  localparam int unsigned T_OGACC = SLOW_GRADE ? 35 : 30;
  localparam int unsigned T_ASU   = 0;

  localparam int unsigned SU_CYC  = ns_to_cycles(T_ASU, CLK_PERIOD_NS);
  localparam int unsigned WP_CYC  = ns_to_cycles(umax(T_PULSE, T_DSU), CLK_PERIOD_NS);
  localparam int unsigned WC_CYC  = ns_to_cycles(T_CYCLE, CLK_PERIOD_NS);
  localparam int unsigned HOLD_CYC = (WC_CYC > SU_CYC + WP_CYC + 1) ?
                                     (WC_CYC - SU_CYC - WP_CYC) : 1;
  localparam int unsigned RD_CYC  = ns_to_cycles(umax(umax(T_ACC, T_OGACC), T_CYCLE),
                                                 CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC = umax(umax(SU_CYC, WP_CYC), umax(HOLD_CYC, RD_CYC));
  localparam int          CNT_W   = $clog2(MAX_CYC + 1);

  logic             load, expired, accept, capture;
  logic [CNT_W-1:0] load_val;

  asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  asram_fsm #(
    .SU_CYC   (SU_CYC),
    .WP_CYC   (WP_CYC),
    .HOLD_CYC (HOLD_CYC),
    .RD_CYC   (RD_CYC),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .expired   (expired),
    .load      (load),
    .load_val  (load_val),
    .accept    (accept),
    .capture   (capture),
    .cs_n      (ram_cs_n),
    .og_n      (ram_og_n),
    .ws_n      (ram_ws_n),
    .dq_oe     (ram_dq_oe),
    .done      (done)
  );

  asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_in     (ram_dq_in),
    .cs_n      (ram_cs_n),
    .addr      (ram_addr),
    .dq_out    (ram_dq_out),
    .rd_data   (rd_data)
  );

  // Checker: length of each write-strobe low run, in cycles.
  logic [CNT_W:0] ws_low_len;

  always_ff @(posedge clk) begin
    if (rst)            ws_low_len <= '0;
    else if (!ram_ws_n) ws_low_len <= ws_low_len + 1'b1;
    else                ws_low_len <= '0;
  end

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_ws_n) |-> (ws_low_len == (CNT_W+1)'(WP_CYC)));

  assert_rd_update_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_data != $past(rd_data)) |-> done);

endmodule

// File: tb/sim_asram_sequencer.sv
module sim_asram_sequencer;

  localparam int CLK_NS = 10;
  localparam int WPB    = ((40 > 25 ? 40 : 25) + CLK_NS - 1) / CLK_NS;
  localparam int WCB    = (55 + CLK_NS - 1) / CLK_NS;
  localparam int HB     = (WCB - 1 - WPB) < 1 ? 1 : (WCB - 1 - WPB);
  localparam int RDB    = (55 + CLK_NS - 1) / CLK_NS;

  typedef struct {
    bit         cs_n, og_n, ws_n, dq_oe, done, rd_done;
    int         kind;
    logic [14:0] addr;
    logic [7:0]  dval;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  rd_data, ram_dq_out, ram_dq_in;
  logic        done, ram_cs_n, ram_og_n, ram_ws_n, ram_dq_oe;
  logic [14:0] ram_addr;

  logic        rv1 = 1'b0, rw1 = 1'b0;
  logic [7:0]  rd1, dqo1, dqi1;
  logic        done1, cs1, og1, ws1, oe1;
  logic [14:0] ad1;

  int checks = 0, fails = 0;
  bit finished = 0;
  exp_t q[$];
  logic [7:0] ram_m [int];
  logic [7:0] ref_m [int];
  logic [7:0] exp_rd = 8'h00;
  int ws_run = 0, cs_run = 0;
  bit prev_cs = 1, prev_og = 1, prev_ws = 1;
  logic [14:0] prev_addr = '0;

  always #(CLK_NS/2) clk = ~clk;

  asram_sequencer u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data), .done(done),
    .ram_cs_n(ram_cs_n), .ram_og_n(ram_og_n), .ram_ws_n(ram_ws_n),
    .ram_addr(ram_addr), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
    .ram_dq_in(ram_dq_in)
  );

  asram_sequencer #(.SLOW_GRADE(1'b1)) u1 (
    .clk(clk), .rst(rst), .req_valid(rv1), .req_write(rw1),
    .req_addr(15'h0042), .req_wdata(8'h3C), .rd_data(rd1), .done(done1),
    .ram_cs_n(cs1), .ram_og_n(og1), .ram_ws_n(ws1),
    .ram_addr(ad1), .ram_dq_out(dqo1), .ram_dq_oe(oe1), .ram_dq_in(dqi1)
  );

  assign dqi1 = (!cs1 && !og1) ? 8'hA5 : 8'h00;
  initial ram_dq_in = 8'h00;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic exp_t mk(input bit c, o, w, e, d, input int k,
                              input logic [14:0] a, input logic [7:0] v);
    exp_t x;
    x.cs_n = c; x.og_n = o; x.ws_n = w; x.dq_oe = e; x.done = d;
    x.rd_done = 0; x.kind = k; x.addr = a; x.dval = v;
    return x;
  endfunction

  task automatic push_write(input logic [14:0] a, input logic [7:0] d);
    q.push_back(mk(0, 1, 1, 0, 0, 1, a, d));
    for (int i = 0; i < WPB; i++) q.push_back(mk(0, 1, 0, 1, 0, 1, a, d));
    for (int i = 0; i < HB; i++)  q.push_back(mk(0, 1, 1, 1, 0, 1, a, d));
    q.push_back(mk(1, 1, 1, 0, 1, 1, a, d));
    ref_m[int'(a)] = d;
  endtask

  task automatic push_read(input logic [14:0] a);
    exp_t x;
    logic [7:0] v;
    v = ref_m.exists(int'(a)) ? ref_m[int'(a)] : 8'h00;
    for (int i = 0; i < RDB; i++) q.push_back(mk(0, 0, 1, 0, 0, 2, a, v));
    x = mk(1, 1, 1, 0, 1, 2, a, v);
    x.rd_done = 1;
    q.push_back(x);
  endtask

  task automatic compare(input exp_t e);
    string tag;
    tag = (e.kind == 0) ? "R9" : (e.kind == 1) ? "R2" : "R4";
    chk({ram_cs_n, ram_og_n, ram_ws_n, ram_dq_oe, done} ==
        {e.cs_n, e.og_n, e.ws_n, e.dq_oe, e.done}, tag, "strobes",
        int'({ram_cs_n, ram_og_n, ram_ws_n, ram_dq_oe, done}),
        int'({e.cs_n, e.og_n, e.ws_n, e.dq_oe, e.done}));
    if (!e.cs_n) chk(ram_addr == e.addr, tag, "addr", int'(ram_addr), int'(e.addr));
    if (e.dq_oe) chk(ram_dq_out == e.dval, tag, "dq_out", int'(ram_dq_out), int'(e.dval));
    if (e.rd_done) exp_rd = e.dval;
    chk(rd_data == exp_rd, "R4", "rd_data", int'(rd_data), int'(exp_rd));
  endtask

  task automatic ram_model();
    chk(!(!ram_ws_n && !ram_og_n), "R6", "ws low with og low", 1, 0);
    chk(!(ram_dq_oe && (!ram_og_n || ram_cs_n)), "R7", "bus drive", 1, 0);
    if (!ram_cs_n && !prev_cs) begin
      chk(ram_addr == prev_addr, "R8", "addr moved", int'(ram_addr), int'(prev_addr));
      chk(ram_og_n == prev_og, "R5", "og moved", int'(ram_og_n), int'(prev_og));
    end
    if (!ram_ws_n) ws_run++;
    else if (!prev_ws) begin
      chk(ws_run == WPB, "R3", "pulse cycles", ws_run, WPB);
      if (!ram_cs_n) ram_m[int'(ram_addr)] = ram_dq_out;
      ws_run = 0;
    end
    if (!ram_cs_n) cs_run++;
    else if (!prev_cs) begin
      chk(cs_run * CLK_NS >= 55, "R3", "cs span ns", cs_run * CLK_NS, 55);
      cs_run = 0;
    end
    ram_dq_in = (!ram_cs_n && !ram_og_n && ram_ws_n) ?
                (ram_m.exists(int'(ram_addr)) ? ram_m[int'(ram_addr)] : 8'h00) : 8'h00;
    prev_cs = ram_cs_n; prev_og = ram_og_n; prev_ws = ram_ws_n; prev_addr = ram_addr;
  endtask

  task automatic step(input bit v, input bit w, input logic [14:0] a, input logic [7:0] d);
    exp_t e;
    bit idle_now;
    @(negedge clk);
    if (q.size() > 0) begin e = q.pop_front(); idle_now = 0; end
    else begin e = mk(1, 1, 1, 0, 0, 0, '0, '0); idle_now = 1; end
    compare(e);
    ram_model();
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    if (v && idle_now) begin
      if (w) push_write(a, d);
      else   push_read(a);
    end
  endtask

  task automatic op(input bit w, input logic [14:0] a, input logic [7:0] d, input bit poke);
    step(1, w, a, d);
    while (q.size() > 0) begin
      if (poke) step(1, ~w, 15'h0ABC, 8'hEE);  // R9: busy requests must be dropped
      else      step(0, 0, '0, '0);
    end
  endtask

  task automatic slow_op(input bit w);
    int wl, cl;
    bit seen;
    logic [7:0] got;
    wl = 0; cl = 0; seen = 0; got = 8'h00;
    @(negedge clk);
    rv1 = 1; rw1 = w;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i == 0) rv1 = 0;
      if (!ws1) wl++;
      if (!cs1) cl++;
      if (done1) begin seen = 1; got = rd1; end
    end
    chk(wl == (w ? 5 : 0), "R10", "slow ws cycles", wl, w ? 5 : 0);
    chk(cl == 7, "R10", "slow cs cycles", cl, 7);
    chk(seen, "R10", "slow done", int'(seen), 1);
    if (!w) chk(got == 8'hA5, "R10", "slow rd_data", int'(got), 8'hA5);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: rest state under reset
    chk({ram_cs_n, ram_og_n, ram_ws_n, ram_dq_oe, done} == 5'b11100, "R1", "reset strobes",
        int'({ram_cs_n, ram_og_n, ram_ws_n, ram_dq_oe, done}), 'h1c);
    chk(rd_data == 8'h00, "R1", "reset rd_data", int'(rd_data), 0);
    rst = 0;
    step(0, 0, '0, '0);
    chk(rd_data == 8'h00 && ram_cs_n, "R1", "after release", int'(rd_data), 0);

    op(0, 15'h0010, 8'h00, 0);          // read of unwritten location
    op(1, 15'h0000, 8'h5A, 0);
    op(1, 15'h7FFF, 8'hFF, 0);
    op(0, 15'h7FFF, 8'h00, 0);
    op(0, 15'h0000, 8'h00, 0);
    op(1, 15'h1234, 8'hC3, 1);          // R9: poke during write
    op(0, 15'h1234, 8'h00, 1);          // R9: poke during read
    op(1, 15'h1234, 8'h0F, 0);          // overwrite
    step(1, 0, 15'h1234, 8'h00);        // back-to-back read
    while (q.size() > 0) step(0, 0, '0, '0);
    op(1, 15'h2AAA, 8'hA5, 0);
    op(0, 15'h2AAA, 8'h00, 0);
    repeat (3) step(0, 0, '0, '0);

    slow_op(1);
    slow_op(0);
    finish_run();
  end

endmodule